// File: doc/BRIEF.md
# Watchdog Timer with Per-CPU Expiry Action

This block is a watchdog timer for a multi-core subsystem. It sits behind a 32-bit read/write strobe port with two word registers: a control word and a running-count word. Once enabled, a prescaler divides the system clock down to a 10-microsecond tick, and each tick advances the running count toward a programmable limit. Software that is still alive writes zero to the count word before the limit is reached, and that starts the timeout interval again.

When the count reaches the limit, the block takes the expiry action chosen in the control word. One option is a one-cycle reset request on any subset of four per-CPU lines. The other, used when the CPU mask is empty and the interrupt enable is set, is a level interrupt to the host. The reset request itself and the interrupt controller are outside the block.

Control word layout (offset 0): bits [27:24] CPU reset mask, bit 23 interrupt enable, bit 22 run enable, bits [21:0] limit. Count word (offset 4): bits [21:0] running count. Every other bit reads as zero.

Top module: `wdog_timer`

## Requirements
- R1: After reset both words read as zero, the timer is stopped, and `cpu_rst` and `irq` are low.
- R2: A write to offset 0 stores bits [27:0]. A read of offset 0 returns them, with bits [31:28] reading zero. While `rd_en` is low, `rdata` is zero.
- R3: While bit 22 is set, the running count read at offset 4 goes up by one every `TICK_CYCLES` clock cycles. A write to either word that sets bit 22 starts the tick phase from zero when the timer was stopped. With `TICK_CYCLES` = T, the count read k cycles after that write edge is min(k / T, limit).
- R4: A write to offset 4 loads the count from bits [21:0] and restarts the tick phase, so writing zero starts the full timeout interval again.
- R5: The count equals the limit k = limit*T cycles after the interval starts. In the cycle after that (k = limit*T + 1), `cpu_rst` equals the mask in bits [27:24] for exactly one cycle.
- R6: After expiry the count holds at the limit until software writes the count word.
- R7: When the CPU mask is zero and bit 23 is set, `irq` rises at k = limit*T + 1. It then stays high until bit 23 or bit 22 is cleared, and drops one cycle after the write that clears it.
- R8: When the CPU mask is nonzero, expiry never raises `irq`, even with bit 23 set.
- R9: While bit 22 is clear, the count does not change except through writes, and no expiry action occurs.
- R10: Writes to offsets other than 0 and 4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Byte offset of the word accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` while `rd_en` is high |
| cpu_rst | output | 4 | Per-CPU reset request pulses |
| irq | output | 1 | Level expiry interrupt |

## Verification
Read data is combinational, so the count is sampled in the same cycle the read strobe is raised. Every result is timed from the write edge that starts the interval. The count is due at min(k/T, limit) k cycles after that edge, and the reset pulse or interrupt is due at k = limit*T + 1. The bench drives inputs at the falling edge and walks k one falling edge at a time. At every step it compares the count, `cpu_rst` and `irq` with values computed from k, so an action one cycle early or late is reported. Clearing the interrupt is checked both one cycle after the clearing write, while `irq` is still high, and two cycles after it, when `irq` must be low.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CPU_N  = 4;
    localparam int CNT_W  = 22;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 3'd4;

    // Bit order is software visible: mask[27:24], irq_en[23], run[22], limit[21:0]
    typedef struct packed {
        logic [CPU_N-1:0] cpu_mask;
        logic             irq_en;
        logic             run;
        logic [CNT_W-1:0] limit;
    } wdog_ctrl_t;

    localparam int CTRL_W = $bits(wdog_ctrl_t);

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_COUNT
    } wdog_sel_e;

    function automatic wdog_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        if (a == OFS_CTRL)
            return SEL_CTRL;
        else if (a == OFS_COUNT)
            return SEL_COUNT;
        return SEL_NONE;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input wdog_ctrl_t c);
        return {{(DATA_W-CTRL_W){1'b0}}, c};
    endfunction

    function automatic logic [DATA_W-1:0] pack_count(input logic [CNT_W-1:0] v);
        return {{(DATA_W-CNT_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [CNT_W-1:0]     cnt,
    output wdog_ctrl_t           ctrl,
    output logic                 cnt_wr,
    output logic [CNT_W-1:0]     cnt_wdata,
    output logic [DATA_W-1:0]    rdata
);

    wdog_sel_e  sel;
    wdog_ctrl_t ctrl_q;
    logic       unused_wdata_hi;

    assign sel             = decode_ofs(addr);
    assign unused_wdata_hi = ^wdata[DATA_W-1:CTRL_W];

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en && sel == SEL_CTRL)
            ctrl_q <= wdog_ctrl_t'(wdata[CTRL_W-1:0]);
    end

    assign ctrl      = ctrl_q;
    assign cnt_wr    = wr_en && (sel == SEL_COUNT);
    assign cnt_wdata = wdata[CNT_W-1:0];

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_CTRL:  rdata = pack_ctrl(ctrl_q);
                SEL_COUNT: rdata = pack_count(cnt);
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int TICK_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);

    localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

    logic [PRE_W-1:0] pre_q;
    logic             wrap;

    assign wrap = (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || restart)
            pre_q <= '0;
        else if (wrap)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    assign tick = run && !restart && wrap;

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             fire
);

    logic [CNT_W-1:0] cnt_q;
    logic             fired_q;
    logic             at_limit;

    assign at_limit = (cnt_q == limit);
    assign fire     = run && at_limit && !fired_q && !load;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && !at_limit)
            cnt_q <= cnt_q + 1'b1;
    end

    // One expiry action per interval; rearmed by a count write or by stopping
    always_ff @(posedge clk) begin
        if (rst || !run || load)
            fired_q <= 1'b0;
        else if (fire)
            fired_q <= 1'b1;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/wdog_action.sv
module wdog_action
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  wdog_ctrl_t       ctrl,
    output logic [CPU_N-1:0] cpu_rst,
    output logic             irq
);

    logic [CPU_N-1:0] rst_q;
    logic             irq_q;
    logic             irq_mode;

    assign irq_mode = ctrl.irq_en && (ctrl.cpu_mask == '0);

    genvar g;
    generate
        for (g = 0; g < CPU_N; g++) begin : g_cpu
            always_ff @(posedge clk) begin
                if (rst)
                    rst_q[g] <= 1'b0;
                else
                    rst_q[g] <= fire && ctrl.cpu_mask[g];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= (irq_q || (fire && irq_mode)) && ctrl.irq_en && ctrl.run;
    end

    assign cpu_rst = rst_q;
    assign irq     = irq_q;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int TICK_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [3:0]        cpu_rst,
    output logic              irq
);

    wdog_ctrl_t       ctrl;
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_wdata;
    logic [CNT_W-1:0] cnt;
    logic             tick;
    logic             fire;

    wdog_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .cnt       (cnt),
        .ctrl      (ctrl),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .rdata     (rdata)
    );

    wdog_prescale #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.run),
        .restart (cnt_wr),
        .tick    (tick)
    );

    wdog_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl.run),
        .tick     (tick),
        .load     (cnt_wr),
        .load_val (cnt_wdata),
        .limit    (ctrl.limit),
        .cnt      (cnt),
        .fire     (fire)
    );

    wdog_action u_act (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .ctrl    (ctrl),
        .cpu_rst (cpu_rst),
        .irq     (irq)
    );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
    import wdog_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             irq_en,
    input logic [CPU_N-1:0] mask,
    input logic [CNT_W-1:0] limit,
    input logic [CNT_W-1:0] cnt,
    input logic             cnt_wr,
    input logic [CPU_N-1:0] cpu_rst,
    input logic             irq
);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)); // R3

    AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
        (cpu_rst != '0) |=> (cpu_rst == '0)); // R5

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == limit && !cnt_wr) |=> (cnt == $past(cnt))); // R6

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(irq_en) && $past(run))); // R7

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(mask) == '0)); // R8

    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt)); // R9

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cpu_rst != '0) |-> $past(run)); // R9

endmodule

bind wdog_timer wdog_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl.run),
    .irq_en  (ctrl.irq_en),
    .mask    (ctrl.cpu_mask),
    .limit   (ctrl.limit),
    .cnt     (cnt),
    .cnt_wr  (cnt_wr),
    .cpu_rst (cpu_rst),
    .irq     (irq)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;

    localparam int T = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  cpu_rst;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    wdog_timer #(.TICK_CYCLES(T)) i_wdog_timer (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .cpu_rst (cpu_rst),
        .irq     (irq)
    );

    function automatic logic [31:0] ctrl_word(input logic [3:0] m, input logic ie,
                                              input logic en, input int lim);
        return {4'b0, m, ie, en, 22'(lim)};
    endfunction

    function automatic int exp_cnt(input int k, input int lim);
        return ((k / T) < lim) ? (k / T) : lim;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_en = 1'b1;
        addr  = a;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    // Arms with count zero and walks k from the enabling write edge
    task automatic run_interval(input int lim, input logic [3:0] m, input logic ie);
        logic [31:0] d;
        logic        irq_exp;
        wr(3'd0, 32'h0);
        wr(3'd4, 32'h0);
        wr(3'd0, ctrl_word(m, ie, 1'b1, lim));
        for (int k = 1; k <= lim * T + 3; k++) begin
            @(negedge clk);
            rd(3'd4, d);
            check("R3 count", d, 32'(exp_cnt(k, lim)));
            check("R5 cpu_rst", {28'b0, cpu_rst}, (k == lim * T + 1) ? {28'b0, m} : 32'h0);
            irq_exp = ie && (m == 4'h0) && (k >= lim * T + 1);
            if (irq_exp)
                check("R7 irq", {31'b0, irq}, 32'h1);
            else
                check("R8 irq", {31'b0, irq}, 32'h0);
        end
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int          lim;
        logic [3:0]  m;
        logic        ie;
        bit          saw;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, d); check("R1 ctrl", d, 32'h0);
        rd(3'd4, d); check("R1 count", d, 32'h0);
        check("R1 cpu_rst", {28'b0, cpu_rst}, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 unused bits and read strobe
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d); check("R2 readback", d, 32'h0FFF_FFFF);
        #1; check("R2 no strobe", rdata, 32'h0);
        wr(3'd0, 32'h0);
        wr(3'd0, 32'hA5_0012_34);
        rd(3'd0, d); check("R2 pattern", d, 32'h0500_1234);
        wr(3'd0, 32'h0);

        // R10 unmapped offsets
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd0, d); check("R10 ctrl", d, 32'h0);
        rd(3'd4, d); check("R10 count", d, 32'h0);

        // R9 stopped timer
        wr(3'd0, ctrl_word(4'hF, 1'b1, 1'b0, 1));
        saw = 0;
        repeat (30) begin
            @(negedge clk);
            if (cpu_rst != 0 || irq) saw = 1;
        end
        check("R9 no action", {31'b0, saw}, 32'h0);
        rd(3'd4, d); check("R9 count frozen", d, 32'h0);

        // Directed corners: limit zero, single CPU, irq mode, mask overrides irq
        run_interval(0, 4'h2, 1'b0);
        run_interval(3, 4'hF, 1'b0);
        run_interval(2, 4'h0, 1'b1);

        // R7 irq stays, then clears one cycle after the clearing write
        repeat (10) @(negedge clk);
        check("R7 irq held", {31'b0, irq}, 32'h1);
        rd(3'd4, d); check("R6 hold at limit", d, 32'd2);
        wr(3'd0, ctrl_word(4'h0, 1'b0, 1'b1, 2));
        check("R7 irq one cycle after", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R7 irq cleared", {31'b0, irq}, 32'h0);

        run_interval(2, 4'h5, 1'b1);

        // R6 hold long after expiry, no repeated pulse
        saw = 0;
        repeat (25) begin
            @(negedge clk);
            if (cpu_rst != 0) saw = 1;
        end
        check("R6 no repeat", {31'b0, saw}, 32'h0);
        rd(3'd4, d); check("R6 hold", d, 32'd2);

        // R4 restart mid-interval with a zero write
        wr(3'd0, 32'h0);
        wr(3'd4, 32'h0);
        wr(3'd0, ctrl_word(4'h9, 1'b0, 1'b1, 5));
        repeat (10) @(negedge clk);
        rd(3'd4, d); check("R4 before restart", d, 32'd2);
        wr(3'd4, 32'h0);
        rd(3'd4, d); check("R4 count zeroed", d, 32'h0);
        saw = 0;
        for (int k = 1; k <= 5 * T + 2; k++) begin
            @(negedge clk);
            if (k == 5 * T + 1)
                check("R4 pulse after restart", {28'b0, cpu_rst}, 32'h9);
            else if (cpu_rst != 0)
                saw = 1;
        end
        check("R4 no early pulse", {31'b0, saw}, 32'h0);

        // R4 loading a nonzero count shortens the interval
        wr(3'd4, 32'd3);
        for (int k = 1; k <= 2 * T + 2; k++) begin
            @(negedge clk);
            check("R4 preload", {28'b0, cpu_rst}, (k == 2 * T + 1) ? 32'h9 : 32'h0);
        end

        // Random intervals
        for (int i = 0; i < 10; i++) begin
            lim = int'($urandom_range(6, 1));
            m   = 4'($urandom_range(15, 0));
            ie  = 1'($urandom_range(1, 0));
            run_interval(lim, m, ie);
        end

        wr(3'd0, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule